// File: doc/BRIEF.md
# Chip-Select Decoder with Wait-State Timing

This block sits between a bus master and a set of external memory banks. Each bank has a chip select with two 32-bit configuration words. The control word holds an enable bit, a memory kind and a region select. The timing word holds packed wait-state fields. All banks share one region mask. For every bus request the block finds the chip select whose 4 MB-aligned region claims the address. It raises that chip select and a hit flag, and it returns a one-cycle ready pulse once the wait-state delay for that bank has run out.

The delay depends on the memory kind and on the direction of the access:

- Asynchronous banks sum several timing fields, and the fields used for reads differ from those used for writes.
- SDRAM banks use a small constant plus a CAS latency field.
- SSRAM banks and synchronous banks use a fixed delay.

Address decode and delay selection are combinational from the live configuration words. The outcome of an accepted request is held in registers until the next request is accepted.

Control word layout: bit 0 enables the bank, bits 2:1 hold the bus width (carried, not decoded), bits 6:4 hold the memory kind, and bits 23:16 hold the region select.

Top module: `cs_timing_decoder`

## Requirements
- R1: An enabled chip select matches when (addr AND (mask << 22)) equals (select << 22). The select sits in control bits 23:16 and the mask is the 8-bit shared input, so only address bits 29:22 take part in the compare and bits 31:30 and 21:0 are ignored.
- R2: A chip select whose control bit 0 is 0 never matches, whatever its select and the address.
- R3: When several chip selects match, only the lowest-numbered one is driven on the one-hot output, and the hit flag is 1.
- R4: When no chip select matches, the chip-select output is all zeros, the hit flag is 0, and ready still arrives after 1 cycle.
- R5: For memory kind 2 (asynchronous), a read waits timing[7:0] + timing[11:8] cycles.
- R6: For memory kind 2 (asynchronous), a write waits timing[15:12] + timing[19:16] + timing[25:20] cycles.
- R7: For memory kind 0 (SDRAM), reads and writes wait 3 + timing[5:4] cycles.
- R8: Memory kinds 1 (SSRAM) and 3 (synchronous) wait 2 cycles for reads and writes. The unused kinds 4 to 7 also wait 2 cycles.
- R9: A request is accepted on a rising edge where the block is idle. Ready goes high for exactly one cycle, D rising edges after the accepting edge, where D is the delay of R4 to R8. A computed delay of 0 is raised to 1.
- R10: A request presented while an access is in progress is ignored. The chip-select output, the hit flag and the ready timing of the current access do not change.
- R11: A change to the configuration words during an access does not alter that access. The next accepted request uses the new values.
- R12: During and right after reset, the chip-select output, the hit flag and ready are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| csc_all_i | input | NUM_CS*32 | Control words, bank g at bits g*32 upward |
| tms_all_i | input | NUM_CS*32 | Timing words, bank g at bits g*32 upward |
| region_mask_i | input | SEL_W | Shared region mask, shifted by 22 before use |
| req_i | input | 1 | Access request, taken when idle |
| wr_i | input | 1 | 1 for write, 0 for read |
| addr_i | input | ADDR_W | Bus address |
| cs_o | output | NUM_CS | One-hot chip select of the accepted access |
| hit_o | output | 1 | Accepted access claimed by a bank |
| rdy_o | output | 1 | One-cycle ready pulse at the end of the wait |

## Verification
The chip-select output and the hit flag are registered on the accepting edge. The bench therefore samples them on the falling edge right after that edge. Ready is due D rising edges after acceptance. The bench counts falling edges from acceptance until ready appears, compares that count with the delay its own functions compute, and then checks that ready is low one cycle later. During accesses where the request is held or the configuration is changed, the chip-select output is re-sampled on every falling edge until ready.

// File: rtl/csdec_pkg.sv
// Package: shared field positions and memory-kind codes for the
// chip-select timing decoder. Assumes 32-bit configuration words.
package csdec_pkg;
    localparam int REG_W   = 32;
    localparam int EN_BIT  = 0;
    localparam int KIND_LO = 4;
    localparam int KIND_W  = 3;
    localparam int SEL_LO  = 16;
    localparam int DLY_W   = 9;

    typedef enum logic [KIND_W-1:0] {
        MK_SDRAM = 3'd0,
        MK_SSRAM = 3'd1,
        MK_ASYNC = 3'd2,
        MK_SYNC  = 3'd3
    } mem_kind_e;
endpackage

// File: rtl/cs_region_match.sv
// Module: compares one bank's region select against the bus address
// under the shared mask. Assumes SEL_W + SHIFT <= ADDR_W.
module cs_region_match
    import csdec_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SEL_W  = 8,
    parameter int SHIFT  = 22
) (
    input  logic [REG_W-1:0]  csc_i,
    input  logic [SEL_W-1:0]  mask_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              match_o
);
    logic [ADDR_W-1:0] mask_w;
    logic [ADDR_W-1:0] sel_w;

    // Align mask and select to the region boundary, then compare.
    always_comb begin
        mask_w  = ADDR_W'(mask_i) << SHIFT;
        sel_w   = ADDR_W'(csc_i[SEL_LO +: SEL_W]) << SHIFT;
        match_o = csc_i[EN_BIT] && ((addr_i & mask_w) == sel_w);
    end
endmodule

// File: rtl/cs_prio_pick.sv
// Module: fixed-priority picker, lowest index wins. Output is one-hot
// or zero.
module cs_prio_pick #(
    parameter int N = 4
) (
    input  logic [N-1:0] req_i,
    output logic [N-1:0] pick_o,
    output logic         any_o
);
    // Scan from the top down so the lowest set index is kept last.
    always_comb begin
        pick_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                pick_o    = '0;
                pick_o[i] = 1'b1;
            end
        end
        any_o = |req_i;
    end
endmodule

// File: rtl/cs_delay_calc.sv
// Module: derives the wait-state count from one timing word, the memory
// kind and the access direction. Purely combinational.
module cs_delay_calc
    import csdec_pkg::*;
(
    input  logic [REG_W-1:0]  tms_i,
    input  logic [KIND_W-1:0] kind_i,
    input  logic              wr_i,
    output logic [DLY_W-1:0]  dly_o
);
    logic [DLY_W-1:0] async_rd;
    logic [DLY_W-1:0] async_wr;

    // Field sums for asynchronous banks.
    always_comb begin
        async_rd = DLY_W'(tms_i[7:0]) + DLY_W'(tms_i[11:8]);
        async_wr = DLY_W'(tms_i[15:12]) + DLY_W'(tms_i[19:16]) + DLY_W'(tms_i[25:20]);
    end

    // Select the formula by memory kind.
    always_comb begin
        case (mem_kind_e'(kind_i))
            MK_ASYNC: dly_o = wr_i ? async_wr : async_rd;
            MK_SDRAM: dly_o = DLY_W'(3) + DLY_W'(tms_i[5:4]);
            default:  dly_o = DLY_W'(2);
        endcase
    end
endmodule

// File: rtl/cs_wait_ctr.sv
// Module: down-counter that runs for the loaded number of cycles and then
// emits a one-cycle ready pulse. Assumes load_i >= 1.
module cs_wait_ctr
    import csdec_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [DLY_W-1:0] load_i,
    output logic             busy_o,
    output logic             rdy_o
);
    logic [DLY_W-1:0] cnt_q;

    // Load on start, count down while busy, pulse ready on the last count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            busy_o <= 1'b0;
            rdy_o  <= 1'b0;
        end else begin
            rdy_o <= 1'b0;
            if (start_i) begin
                cnt_q  <= load_i;
                busy_o <= 1'b1;
            end else if (busy_o) begin
                if (cnt_q == DLY_W'(1)) begin
                    busy_o <= 1'b0;
                    rdy_o  <= 1'b1;
                end else begin
                    cnt_q <= cnt_q - DLY_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/cs_timing_decoder.sv
// Module: top of the chip-select decoder. It decodes the address against
// every bank, picks the lowest matching bank, computes its wait count and
// times the access. Assumes requests are only taken while idle.
module cs_timing_decoder
    import csdec_pkg::*;
#(
    parameter int NUM_CS       = 4,
    parameter int ADDR_W       = 32,
    parameter int SEL_W        = 8,
    parameter int REGION_SHIFT = 22
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_CS*REG_W-1:0] csc_all_i,
    input  logic [NUM_CS*REG_W-1:0] tms_all_i,
    input  logic [SEL_W-1:0]        region_mask_i,
    input  logic                    req_i,
    input  logic                    wr_i,
    input  logic [ADDR_W-1:0]       addr_i,
    output logic [NUM_CS-1:0]       cs_o,
    output logic                    hit_o,
    output logic                    rdy_o
);
    logic [NUM_CS-1:0] match_vec;
    logic [NUM_CS-1:0] pick_vec;
    logic              pick_any;
    logic [REG_W-1:0]  win_csc;
    logic [REG_W-1:0]  win_tms;
    logic [DLY_W-1:0]  raw_dly;
    logic [DLY_W-1:0]  load_dly;
    logic              busy;
    logic              accept;

    for (genvar g = 0; g < NUM_CS; g++) begin : g_bank
        cs_region_match #(
            .ADDR_W(ADDR_W),
            .SEL_W (SEL_W),
            .SHIFT (REGION_SHIFT)
        ) u_match (
            .csc_i  (csc_all_i[g*REG_W +: REG_W]),
            .mask_i (region_mask_i),
            .addr_i (addr_i),
            .match_o(match_vec[g])
        );
    end

    cs_prio_pick #(.N(NUM_CS)) u_pick (
        .req_i (match_vec),
        .pick_o(pick_vec),
        .any_o (pick_any)
    );

    // One-hot mux of the winning bank's configuration words.
    always_comb begin
        win_csc = '0;
        win_tms = '0;
        for (int i = 0; i < NUM_CS; i++) begin
            win_csc |= {REG_W{pick_vec[i]}} & csc_all_i[i*REG_W +: REG_W];
            win_tms |= {REG_W{pick_vec[i]}} & tms_all_i[i*REG_W +: REG_W];
        end
    end

    cs_delay_calc u_dly (
        .tms_i (win_tms),
        .kind_i(win_csc[KIND_LO +: KIND_W]),
        .wr_i  (wr_i),
        .dly_o (raw_dly)
    );

    // A miss or a zero delay still takes one cycle.
    always_comb begin
        if (!pick_any || raw_dly == '0) load_dly = DLY_W'(1);
        else                            load_dly = raw_dly;
    end

    assign accept = req_i && !busy;

    // Hold the decode result of the accepted access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_o  <= '0;
            hit_o <= 1'b0;
        end else if (accept) begin
            cs_o  <= pick_vec;
            hit_o <= pick_any;
        end
    end

    cs_wait_ctr u_wait (
        .clk    (clk),
        .rst_n  (rst_n),
        .start_i(accept),
        .load_i (load_dly),
        .busy_o (busy),
        .rdy_o  (rdy_o)
    );
endmodule

// File: rtl/cs_timing_decoder_chk.sv
// Checker: temporal properties of the chip-select decoder, bound to the top.
module cs_timing_decoder_chk #(
    parameter int NUM_CS = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_CS-1:0] cs_o,
    input logic              hit_o,
    input logic              rdy_o,
    input logic              busy,
    input logic              req_i
);
    p_onehot_cs_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cs_o));

    p_hit_agrees_r4: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o == (cs_o != '0));

    p_single_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rdy_o |=> !rdy_o);

    p_rdy_ends_wait_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rdy_o) |-> $past(busy));

    p_hold_while_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(cs_o) && $stable(hit_o));

    p_take_when_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !busy) |=> busy);
endmodule

bind cs_timing_decoder cs_timing_decoder_chk #(.NUM_CS(NUM_CS)) u_chk (
    .clk  (clk),
    .rst_n(rst_n),
    .cs_o (cs_o),
    .hit_o(hit_o),
    .rdy_o(rdy_o),
    .busy (busy),
    .req_i(req_i)
);

// File: tb/cs_timing_decoder_tb.sv
`timescale 1ns/1ps
module cs_timing_decoder_tb;
    localparam int NCS = 4;
    localparam int AW  = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [31:0]     csc_r [NCS];
    logic [31:0]     tms_r [NCS];
    logic [NCS*32-1:0] csc_all;
    logic [NCS*32-1:0] tms_all;
    logic [7:0]      mask = 8'hFF;
    logic            req = 1'b0;
    logic            wr = 1'b0;
    logic [AW-1:0]   addr = '0;
    logic [NCS-1:0]  cs;
    logic            hit;
    logic            rdy;
    int              checks = 0;
    int              errors = 0;

    always #4 clk = ~clk;

    for (genvar g = 0; g < NCS; g++) begin : g_pack
        assign csc_all[g*32 +: 32] = csc_r[g];
        assign tms_all[g*32 +: 32] = tms_r[g];
    end

    cs_timing_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .csc_all_i(csc_all), .tms_all_i(tms_all),
        .region_mask_i(mask), .req_i(req), .wr_i(wr), .addr_i(addr),
        .cs_o(cs), .hit_o(hit), .rdy_o(rdy)
    );

    task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_csc(input bit en, input int kind, input int sel);
        return (32'(sel) << 16) | (32'(kind) << 4) | 32'(en);
    endfunction

    // Expected one-hot select: lowest enabled bank whose masked region matches.
    function automatic logic [NCS-1:0] exp_cs(input logic [31:0] a);
        for (int i = 0; i < NCS; i++) begin
            if (csc_r[i][0] &&
                ((a & (32'(mask) << 22)) == (((csc_r[i] >> 16) & 32'hFF) << 22)))
                return NCS'(1) << i;
        end
        return '0;
    endfunction

    function automatic int exp_dly(input logic [NCS-1:0] sel, input bit w);
        int d;
        int k;
        logic [31:0] t;
        if (sel == '0) return 1;
        for (int i = 0; i < NCS; i++) if (sel[i]) begin k = int'((csc_r[i] >> 4) & 7); t = tms_r[i]; end
        if (k == 2) d = w ? int'(((t >> 12) & 15) + ((t >> 16) & 15) + ((t >> 20) & 63))
                          : int'((t & 255) + ((t >> 8) & 15));
        else if (k == 0) d = 3 + int'((t >> 4) & 3);
        else d = 2;
        return (d == 0) ? 1 : d;
    endfunction

    // One access: check decode after the accepting edge and ready timing.
    task automatic run_access(input logic [31:0] a, input bit w, input bit hold,
                              input string ctag, input string dtag);
        logic [NCS-1:0] ecs;
        int ed;
        int n;
        ecs = exp_cs(a);
        ed  = exp_dly(ecs, w);
        @(negedge clk);
        addr = a; wr = w; req = 1'b1;
        @(negedge clk);
        if (!hold) req = 1'b0;
        chk(cs == ecs, ctag, cs, ecs);
        chk(hit == (ecs != '0), ctag, hit, ecs != '0);
        n = 0;
        while (!rdy && n < 600) begin
            @(negedge clk);
            n++;
            if (hold) begin
                chk(cs == ecs, "R10", cs, ecs);
                addr = $urandom;
            end
        end
        req = 1'b0;
        chk(n == ed, dtag, n, ed);
        @(negedge clk);
        chk(rdy == 1'b0, "R9", rdy, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL R9 watchdog actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED1234));
        for (int i = 0; i < NCS; i++) begin csc_r[i] = '0; tms_r[i] = '0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(cs == '0 && !hit && !rdy, "R12", {cs, hit, rdy}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cs == '0 && !hit && !rdy, "R12", {cs, hit, rdy}, 0);

        // R2: disabled bank 0 shares region 1 with bank 1.
        csc_r[0] = mk_csc(0, 3, 1); csc_r[1] = mk_csc(1, 1, 1);
        run_access(32'h0040_0010, 0, 0, "R2", "R8");
        chk(cs == 4'b0010, "R2", cs, 4'b0010);
        // R3: banks 1 and 2 overlap in region 2.
        csc_r[1] = mk_csc(1, 3, 2); csc_r[2] = mk_csc(1, 1, 2);
        run_access(32'h0080_1234, 1, 0, "R3", "R8");
        // R4: miss.
        run_access(32'h0240_0000, 0, 0, "R4", "R4");
        chk(hit == 1'b0, "R4", hit, 0);
        // R1: narrowed mask and ignored high bits.
        mask = 8'hFC; csc_r[3] = mk_csc(1, 6, 4);
        run_access(32'hC1FF_FFFF, 0, 0, "R1", "R8");
        mask = 8'hFF;
        // R5 and R6: asynchronous field sums.
        csc_r[0] = mk_csc(1, 2, 5);
        tms_r[0] = (32'd40 << 20) | (32'd7 << 16) | (32'd5 << 12) | (32'd9 << 8) | 32'd200;
        run_access(32'h0140_0000, 0, 0, "R1", "R5");
        run_access(32'h0140_0004, 1, 0, "R1", "R6");
        // R9: zero delay raised to one.
        tms_r[0] = '0;
        run_access(32'h0140_0000, 0, 0, "R1", "R9");
        // R7: SDRAM with CAS field 3, both directions.
        csc_r[0] = mk_csc(1, 0, 6); tms_r[0] = 32'hFFFF_FFF0 | 32'h30;
        run_access(32'h0180_0000, 0, 0, "R1", "R7");
        run_access(32'h0180_0000, 1, 0, "R1", "R7");
        // R10: request held high with changing address while busy.
        csc_r[0] = mk_csc(1, 2, 5); tms_r[0] = 32'd30;
        run_access(32'h0140_0000, 0, 1, "R10", "R10");

        // R11: configuration change during an access.
        begin
            int n;
            csc_r[0] = mk_csc(1, 2, 7); tms_r[0] = 32'd20;
            @(negedge clk); addr = 32'h01C0_0000; wr = 0; req = 1'b1;
            @(negedge clk); req = 1'b0;
            csc_r[0] = mk_csc(1, 1, 8); tms_r[0] = 32'd99;
            n = 0;
            while (!rdy && n < 600) begin
                @(negedge clk); n++;
                chk(cs == 4'b0001, "R11", cs, 4'b0001);
            end
            chk(n == 20, "R11", n, 20);
            @(negedge clk);
            run_access(32'h01C0_0000, 0, 0, "R11", "R11");
            chk(hit == 1'b0, "R11", hit, 0);
            run_access(32'h0200_0000, 0, 0, "R11", "R11");
        end

        // Constrained random: small region set so overlaps and misses occur.
        for (int it = 0; it < 80; it++) begin
            logic [31:0] a;
            for (int i = 0; i < NCS; i++) begin
                csc_r[i] = mk_csc(($urandom % 5) != 0, $urandom % 8, $urandom % 4);
                tms_r[i] = $urandom;
                if ((it % 3) == 0) tms_r[i] = tms_r[i] & 32'hFFFF_F03F;
            end
            mask = ((it % 4) == 0) ? 8'hFE : 8'hFF;
            a = $urandom;
            a[29:22] = 8'($urandom % 5);
            run_access(a, $urandom % 2, 0, "R1", "R9");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule